// File: doc/BRIEF.md
# Pipelined Tower-Field AES Substitution Box

This block applies the AES SubBytes substitution to one byte per clock and uses no lookup table. Each input byte is an element of GF(2^8) reduced by x^8 + x^4 + x^3 + x + 1. A fixed linear change of basis moves the byte into a three-level tower field built as GF(((2^2)^2)^2), with every level held in a normal basis. The top level is a quadratic extension whose linear coefficient is unity. The middle level is a quadratic extension whose constant coefficient is unity. The bottom level uses w^2 + w + 1. The inverse is formed there, with zero mapping to zero. A second fixed linear map then returns the result to the standard basis, and the AES affine transform is folded into that same map.

The arithmetic is split into five merged logic stages with a register after each one. The first stage changes the basis. The second adds the two halves, squares and scales the sum, multiplies the halves and adds the two products. The third inverts the resulting 4-bit norm. The fourth forms both output halves with two 4-bit multipliers. The fifth maps back and applies the affine transform. Both halves of the byte ride along beside the norm, so the parallel paths meet in the right cycle.

The byte stream enters and leaves through valid/ready handshakes. The whole pipeline advances together. It holds still only when its last stage holds a result that the consumer is not taking. The ready output therefore depends combinationally on the ready input, and the two must not be joined in a loop outside the block.

Top module: `sbox_nb_pipe`

## Requirements
- R1: For every accepted byte a, the output is the AES S-box value. Bit i of a is the coefficient of x^i. Examples: 0x01 gives 0x7C, 0x53 gives 0xED, 0xFF gives 0x16, 0xAA gives 0xAC.
- R2: With out_rdy held high, a byte accepted at a rising edge appears on out_data with out_vld high after the fifth rising edge counted from that one. No more than five results are ever in flight.
- R3: While out_rdy is high, in_rdy is high, so one byte per clock is accepted with no bubbles.
- R4: in_rdy is high exactly when out_vld is low or out_rdy is high.
- R5: While out_vld is high and out_rdy is low, out_vld stays high and out_data stays unchanged on the next cycle.
- R6: A synchronous, active-high rst empties the pipeline. out_vld is low in the first cycle after reset, bytes accepted before reset are never delivered, and in_rdy is high once reset is released.
- R7: A cycle in which in_vld is low or in_rdy is low accepts nothing. Each accepted byte yields exactly one output, in acceptance order, and no output appears without an accepted byte.
- R8: Input 0x00, which has no field inverse, is treated as inverting to 0x00 and yields 0x63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input byte is valid |
| in_rdy | output | 1 | Block accepts the input byte at this edge |
| in_data | input | 8 | Byte to substitute |
| out_vld | output | 1 | Output byte is valid |
| out_rdy | input | 1 | Consumer takes the output byte at this edge |
| out_data | output | 8 | Substituted byte |

## Verification
Nine hand-picked bytes with known substitutes come first. They include zero, one, all-ones and single-bit values, and they separate a wrong basis matrix or a wrong affine constant from a fault in the inverse itself. Then all 256 bytes are streamed back to back and compared with a reference that inverts by raising to the 254th power. This run catches an error in a single product term, and it confirms that the output arrives five cycles after acceptance when the stream is full. An irregular out_rdy pattern then exercises stalls while in_vld is held high. A mistaken extra acceptance or a dropped hold would show up there as a missing, repeated or reordered result. Finally, idle cycles with changing data and a reset in the middle of a stream show that nothing leaks out when it should not.

// File: rtl/sbox_tower_pkg.sv
`timescale 1ns/1ps
package sbox_tower_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned PAIR_W = NIB_W / 2;
  localparam int unsigned STAGES = 5;

  typedef logic [PAIR_W-1:0]        gf4_t;
  typedef logic [NIB_W-1:0]         gf16_t;
  typedef logic [BYTE_W-1:0]        gf256_t;
  typedef logic [BYTE_W*BYTE_W-1:0] bmat_t;

  // GF(4), normal basis {W^2, W}: bit 1 is the W^2 coefficient, bit 0 the W coefficient.
  localparam gf4_t G4_T    = 2'b01;  // middle-level trace T = W
  localparam gf4_t G4_TINV = 2'b10;  // 1/T = W^2 (N = 1, so N/T = W^2)
  localparam gf4_t G4_TSQ  = 2'b10;  // T^2 = W^2
  localparam gf16_t  G16_ONE  = {G4_TINV, G4_TINV};
  localparam gf256_t G256_ONE = {G16_ONE, G16_ONE};

  function automatic gf4_t gf4_mul(gf4_t a, gf4_t b);
    logic e;
    e = (a[1] ^ a[0]) & (b[1] ^ b[0]);
    return {(a[1] & b[1]) ^ e, (a[0] & b[0]) ^ e};
  endfunction

  function automatic gf4_t gf4_sq(gf4_t a);
    return {a[0], a[1]};
  endfunction

  // GF(16) over GF(4), normal basis {Z^4, Z}, z^2 + T z + 1.
  function automatic gf16_t gf16_mul(gf16_t a, gf16_t b);
    gf4_t ah, al, bh, bl, e;
    ah = a[NIB_W-1:PAIR_W]; al = a[PAIR_W-1:0];
    bh = b[NIB_W-1:PAIR_W]; bl = b[PAIR_W-1:0];
    e  = gf4_mul(gf4_mul(ah ^ al, bh ^ bl), G4_TINV);
    return {gf4_mul(gf4_mul(ah, bh), G4_T) ^ e, gf4_mul(gf4_mul(al, bl), G4_T) ^ e};
  endfunction

  function automatic gf16_t gf16_inv(gf16_t a);
    gf4_t ah, al, nrm, ni;
    ah  = a[NIB_W-1:PAIR_W]; al = a[PAIR_W-1:0];
    nrm = gf4_mul(gf4_mul(ah, al), G4_TSQ) ^ gf4_sq(ah ^ al);
    ni  = gf4_sq(nrm);
    return {gf4_mul(al, ni), gf4_mul(ah, ni)};
  endfunction

  // GF(256) over GF(16), normal basis {Y^16, Y}, y^2 + y + nu.
  function automatic gf256_t gf256_mul(gf256_t a, gf256_t b, gf16_t nu);
    gf16_t ah, al, bh, bl, e;
    ah = a[BYTE_W-1:NIB_W]; al = a[NIB_W-1:0];
    bh = b[BYTE_W-1:NIB_W]; bl = b[NIB_W-1:0];
    e  = gf16_mul(gf16_mul(ah ^ al, bh ^ bl), nu);
    return {gf16_mul(ah, bh) ^ e, gf16_mul(al, bl) ^ e};
  endfunction

  // Smallest nu that leaves y^2 + y + nu without a root in GF(16).
  function automatic gf16_t find_nu();
    gf16_t r;
    logic  hit;
    r = '0;
    for (int v = 15; v >= 1; v--) begin
      hit = 1'b0;
      for (int z = 0; z < 16; z++)
        if ((gf16_mul(4'(z), 4'(z)) ^ 4'(z) ^ 4'(v)) == '0) hit = 1'b1;
      if (!hit) r = 4'(v);
    end
    return r;
  endfunction

  // A tower element that is a root of x^8 + x^4 + x^3 + x + 1.
  function automatic gf256_t find_root(gf16_t nu);
    gf256_t r, b, p2, p3, p4, p8;
    r = '0;
    for (int c = 255; c >= 1; c--) begin
      b  = 8'(c);
      p2 = gf256_mul(b, b, nu);
      p3 = gf256_mul(p2, b, nu);
      p4 = gf256_mul(p2, p2, nu);
      p8 = gf256_mul(p4, p4, nu);
      if ((p8 ^ p4 ^ p3 ^ b ^ G256_ONE) == '0) r = b;
    end
    return r;
  endfunction

  // Column j of a matrix sits at bits [8j+7:8j].
  function automatic gf256_t lin_apply(bmat_t m, gf256_t v);
    gf256_t r;
    r = '0;
    for (int j = 0; j < BYTE_W; j++)
      if (v[j]) r = r ^ m[BYTE_W*j +: BYTE_W];
    return r;
  endfunction

  function automatic bmat_t build_iso(gf256_t root, gf16_t nu);
    bmat_t  m;
    gf256_t pw;
    pw = G256_ONE;
    for (int j = 0; j < BYTE_W; j++) begin
      m[BYTE_W*j +: BYTE_W] = pw;
      pw = gf256_mul(pw, root, nu);
    end
    return m;
  endfunction

  function automatic gf256_t affine_lin(gf256_t b);
    gf256_t s;
    for (int i = 0; i < BYTE_W; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return s;
  endfunction

  // Inverse of the basis change, with the linear part of the affine map folded in.
  function automatic bmat_t build_out(bmat_t iso);
    bmat_t m;
    m = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int a = 0; a < 256; a++)
        if (lin_apply(iso, 8'(a)) == (8'(1) << j))
          m[BYTE_W*j +: BYTE_W] = affine_lin(8'(a));
    return m;
  endfunction

  localparam gf16_t  NU       = find_nu();
  localparam gf256_t ROOT     = find_root(NU);
  localparam bmat_t  ISO_M    = build_iso(ROOT, NU);
  localparam bmat_t  OUT_M    = build_out(ISO_M);
  localparam gf256_t AFF_CONST = 8'h63;
endpackage

// File: rtl/sbox_lin_map.sv
`timescale 1ns/1ps
module sbox_lin_map
  import sbox_tower_pkg::*;
#(
  parameter bmat_t  MAT = '0,
  parameter gf256_t OFS = '0
) (
  input  gf256_t x,
  output gf256_t y
);
  assign y = lin_apply(MAT, x) ^ OFS;
endmodule

// File: rtl/sbox_gf16_mul.sv
`timescale 1ns/1ps
module sbox_gf16_mul
  import sbox_tower_pkg::*;
(
  input  gf16_t a,
  input  gf16_t b,
  output gf16_t y
);
  assign y = gf16_mul(a, b);
endmodule

// File: rtl/sbox_norm_unit.sv
`timescale 1ns/1ps
module sbox_norm_unit
  import sbox_tower_pkg::*;
(
  input  gf16_t hi,
  input  gf16_t lo,
  output gf16_t nrm
);
  gf16_t sum, sq_sc, prod;
  assign sum   = hi ^ lo;
  assign sq_sc = gf16_mul(gf16_mul(sum, sum), NU);
  sbox_gf16_mul u_prod (.a(hi), .b(lo), .y(prod));
  assign nrm   = prod ^ sq_sc;
endmodule

// File: rtl/sbox_vld_pipe.sv
`timescale 1ns/1ps
module sbox_vld_pipe #(
  parameter int unsigned DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;
  always_ff @(posedge clk) begin
    if (rst)      sr <= '0;
    else if (adv) sr <= {sr[DEPTH-2:0], d};
  end
  assign q = sr[DEPTH-1];
endmodule

// File: rtl/sbox_nb_pipe.sv
`timescale 1ns/1ps
module sbox_nb_pipe
  import sbox_tower_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  output logic       in_rdy,
  input  logic [7:0] in_data,
  output logic       out_vld,
  input  logic       out_rdy,
  output logic [7:0] out_data
);
  logic adv;
  assign adv    = !out_vld || out_rdy;
  assign in_rdy = adv;

  sbox_vld_pipe #(.DEPTH(STAGES)) u_vld (
    .clk(clk), .rst(rst), .adv(adv), .d(in_vld), .q(out_vld)
  );

  // Stage 1: change of basis
  gf256_t iso_w, s1_t;
  sbox_lin_map #(.MAT(ISO_M), .OFS('0)) u_iso (.x(in_data), .y(iso_w));

  // Stage 2: half sum, square-scale, half product, norm
  gf16_t nrm_w, s2_hi, s2_lo, s2_nrm;
  sbox_norm_unit u_norm (.hi(s1_t[BYTE_W-1:NIB_W]), .lo(s1_t[NIB_W-1:0]), .nrm(nrm_w));

  // Stage 3: invert the norm
  gf16_t s3_hi, s3_lo, s3_ninv;

  // Stage 4: two output-half products
  gf16_t new_hi, new_lo;
  gf256_t s4_inv;
  sbox_gf16_mul u_mul_hi (.a(s3_lo), .b(s3_ninv), .y(new_hi));
  sbox_gf16_mul u_mul_lo (.a(s3_hi), .b(s3_ninv), .y(new_lo));

  // Stage 5: back to standard basis plus affine transform
  gf256_t out_w, s5_out;
  sbox_lin_map #(.MAT(OUT_M), .OFS(AFF_CONST)) u_out (.x(s4_inv), .y(out_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_t    <= '0;
      s2_hi   <= '0;
      s2_lo   <= '0;
      s2_nrm  <= '0;
      s3_hi   <= '0;
      s3_lo   <= '0;
      s3_ninv <= '0;
      s4_inv  <= '0;
      s5_out  <= '0;
    end else if (adv) begin
      s1_t    <= iso_w;
      s2_hi   <= s1_t[BYTE_W-1:NIB_W];
      s2_lo   <= s1_t[NIB_W-1:0];
      s2_nrm  <= nrm_w;
      s3_hi   <= s2_hi;
      s3_lo   <= s2_lo;
      s3_ninv <= gf16_inv(s2_nrm);
      s4_inv  <= {new_hi, new_lo};
      s5_out  <= out_w;
    end
  end

  assign out_data = s5_out;
endmodule

// File: rtl/sbox_nb_pipe_chk.sv
`timescale 1ns/1ps
module sbox_nb_pipe_chk
  import sbox_tower_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_vld,
  input logic       in_rdy,
  input logic       out_vld,
  input logic       out_rdy,
  input logic [7:0] out_data
);
  logic [3:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + 4'(in_vld && in_rdy) - 4'(out_vld && out_rdy);
  end

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst) occ <= 4'(STAGES));
  p_full_rate_r3: assert property (@(posedge clk) disable iff (rst) out_rdy |-> in_rdy);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));
  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_vld);
  p_no_ghost_r7: assert property (@(posedge clk) disable iff (rst) (occ == 4'd0) |-> !out_vld);
  p_known_out_r1: assert property (@(posedge clk) disable iff (rst) out_vld |-> !$isunknown(out_data));
endmodule

bind sbox_nb_pipe sbox_nb_pipe_chk u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
);

// File: tb/test_sbox_nb_pipe.sv
`timescale 1ns/1ps
module test_sbox_nb_pipe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_rdy = 1'b1;
  logic       in_rdy, out_vld;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  sbox_nb_pipe i_sbox_nb_pipe (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
  );

  int checks = 0, fails = 0, cyc = 0, outs = 0, bp_n = 0;
  logic lat_on = 1'b0, bp_on = 1'b0;
  logic [7:0] exp_q[$];
  int acc_q[$];
  string tag_q[$];

  localparam logic [15:0] VEC [9] = '{16'h0063, 16'h017C, 16'h0277, 16'h53ED, 16'hFF16,
                                      16'h10CA, 16'h80CD, 16'h7FD2, 16'hAAAC};

  function automatic logic [7:0] xmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox_ref(logic [7:0] a);
    logic [7:0] r, s;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = xmul(r, r);
      if (i != 0) r = xmul(r, a);  // exponent 254 = 0b11111110
    end
    for (int i = 0; i < 8; i++)
      s[i] = r[i] ^ r[(i+4)%8] ^ r[(i+5)%8] ^ r[(i+6)%8] ^ r[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // out_rdy pattern, changed half a nanosecond after each falling edge
  always @(negedge clk) begin
    #0.5;
    if (bp_on) begin
      bp_n++;
      out_rdy = !((bp_n % 4 == 0) || (bp_n % 7 == 3) || (bp_n % 11 == 5));
    end else begin
      out_rdy = 1'b1;
    end
  end

  // Monitor: samples 1 ns after the falling edge, the values the next rising edge uses
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;
  always @(negedge clk) begin
    #1;
    if (rst) begin
      exp_q.delete(); acc_q.delete(); tag_q.delete();
      prev_stall = 1'b0;
    end else begin
      chk("R4", "in_rdy rule", {15'd0, in_rdy}, {15'd0, (!out_vld || out_rdy)});
      if (prev_stall) begin
        chk("R5", "valid held", {15'd0, out_vld}, 16'd1);
        chk("R5", "data held", {8'd0, out_data}, {8'd0, prev_data});
      end
      if (out_vld && out_rdy) begin
        if (exp_q.size() == 0) begin
          chk("R7", "unexpected output", 16'd1, 16'd0);
        end else begin
          logic [7:0] e;
          int a;
          string t;
          e = exp_q.pop_front(); a = acc_q.pop_front(); t = tag_q.pop_front();
          chk(t, "substitute", {8'd0, out_data}, {8'd0, e});
          if (lat_on) chk("R2", "latency", 16'(cyc - a), 16'd5);
          outs++;
        end
      end
      prev_stall = out_vld && !out_rdy;
      prev_data  = out_data;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Called 0.5 ns after a falling edge; returns at the same phase.
  task automatic send(input logic [7:0] b, input logic [7:0] e, input string t, output int waits);
    logic ok;
    waits = 0;
    in_vld = 1'b1; in_data = b;
    do begin
      #0.5;
      ok = in_rdy;
      if (ok) begin exp_q.push_back(e); acc_q.push_back(cyc); tag_q.push_back(t); end
      else waits++;
      @(negedge clk); #0.5;
    end while (!ok);
    in_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #0.5; end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) idle(1);
    idle(2);
  endtask

  initial begin
    int w, base;
    @(negedge clk); #0.5;
    idle(3);
    rst = 1'b0;
    #0.5;
    chk("R6", "out_vld after reset", {15'd0, out_vld}, 16'd0);
    chk("R6", "in_rdy after reset", {15'd0, in_rdy}, 16'd1);
    @(negedge clk); #0.5;

    // Known vectors (R1, zero entry R8)
    lat_on = 1'b1;
    foreach (VEC[i]) send(VEC[i][15:8], VEC[i][7:0], (VEC[i][15:8] == 8'h00) ? "R8" : "R1", w);
    drain();

    // All 256 bytes back to back (R1, R2, R3)
    base = outs;
    for (int i = 0; i < 256; i++) begin
      send(8'(i), sbox_ref(8'(i)), "R1", w);
      chk("R3", "stall while streaming", 16'(w), 16'd0);
    end
    drain();
    chk("R7", "one output per byte", 16'(outs - base), 16'd256);

    // Back-pressure (R4, R5, R7)
    lat_on = 1'b0; bp_on = 1'b1;
    base = outs;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 11) & 255);
      send(b, sbox_ref(b), "R5", w);
    end
    drain();
    bp_on = 1'b0;
    idle(2);
    chk("R7", "count under stalls", 16'(outs - base), 16'd40);

    // Input ignored while in_vld is low (R7)
    for (int i = 0; i < 10; i++) begin
      in_data = 8'(i * 13 + 1);
      #0.5;
      chk("R7", "no output when idle", {15'd0, out_vld}, 16'd0);
      @(negedge clk); #0.5;
    end

    // Reset in mid-stream (R6)
    base = outs;
    send(8'h21, sbox_ref(8'h21), "R6", w);
    send(8'h42, sbox_ref(8'h42), "R6", w);
    send(8'h84, sbox_ref(8'h84), "R6", w);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #0.5;
      chk("R6", "flushed by reset", {15'd0, out_vld}, 16'd0);
      @(negedge clk); #0.5;
    end
    chk("R6", "nothing delivered after reset", 16'(outs - base), 16'd0);

    // Recovery after reset, zero byte again (R8)
    lat_on = 1'b1;
    send(8'h00, 8'h63, "R8", w);
    send(8'h53, 8'hED, "R1", w);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule